// File: doc/BRIEF.md
# Clipped rectangle fill engine

This block fills a solid rectangle in a one-bit-per-pixel frame buffer that is organised as 32-bit words. A command gives a destination base pointer (a high part that selects page and plane and a 16-bit low part), a row pitch in words, the rectangle origin and size, a raster mode (clear, set or toggle) and an optional clip window. The engine walks the covered words row by row. It reads a word and writes it back when only part of it changes or when the mode needs the old value. It writes a fully covered word directly in clear and set modes.

A command is accepted on a one-cycle `start_i` pulse while the engine is idle. All command inputs are sampled on that cycle. Memory traffic uses a single request/acknowledge port. Completion is signalled by a one-cycle `done_o` pulse. The command processor that feeds this block is expected to have validated the pitch and coordinates already.

Top module: `rfill_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_req_o` are all low.
- R2: The word holding pixel (px, py) is at address base + py*pitch + floor(px/32). Here base = dest_hi*65536 + dest_lo, so dest_hi = 1 with dest_lo = 0 starts page 1. Writes proceed from the top row down, and from left to right within a row, with one write per covered word.
- R3: Bit 31 of a word is its leftmost pixel and bit 0 its rightmost. In a partly covered word, bits for pixels outside the rectangle keep their old value.
- R4: The mode code on `alu_mode_i` selects the operation: 2 sets covered pixels to 1, 3 inverts them, and 1 and 0 both clear them to 0.
- R5: A fully covered word in mode 0, 1 or 2 is written with no read. Every other covered word is read first and then written back to the same address in the following request.
- R6: With `clip_en_i` = 1, only pixels inside both the rectangle and the clip window [clip_x, clip_x+clip_w) x [clip_y, clip_y+clip_h) are modified. An empty intersection causes no memory access.
- R7: With `clip_en_i` = 0, the clip window inputs have no effect on which pixels are modified.
- R8: A command with zero width or zero height makes no memory access, and `done_o` is high in the cycle after the start cycle.
- R9: While `mem_req_o` is high and `mem_ack_i` is low, the request stays asserted and `mem_addr_o`, `mem_we_o` and `mem_wdata_o` hold their values.
- R10: `busy_o` is high from the cycle after an accepted start until the final write is acknowledged. `done_o` pulses for exactly one cycle after that acknowledge, with `busy_o` low. A `start_i` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; command inputs are sampled with it |
| alu_mode_i | input | 2 | Raster mode: 0/1 clear, 2 set, 3 toggle |
| dest_hi_i | input | HW (3) | Destination pointer high part (page in bit 0) |
| dest_lo_i | input | LW (16) | Destination pointer low part |
| pitch_i | input | PW (7) | Row pitch in 32-bit words |
| x_i | input | CW (11) | Rectangle left edge |
| y_i | input | CW (11) | Rectangle top edge |
| w_i | input | CW (11) | Rectangle width in pixels |
| h_i | input | CW (11) | Rectangle height in rows |
| clip_en_i | input | 1 | Enable clipping to the clip window |
| clip_x_i | input | CW (11) | Clip window left edge |
| clip_y_i | input | CW (11) | Clip window top edge |
| clip_w_i | input | CW (11) | Clip window width |
| clip_h_i | input | CW (11) | Clip window height |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW (19) | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Acknowledge of the current request |

## Verification
Directed cases cover single-word rectangles that start and end inside one word. They also cover word-aligned spans, where clear and set must skip the read but toggle must not, and page-1 pointers. Zero-size commands, clip windows that cut the rectangle on each side, windows that miss it entirely, and the same window with clipping disabled separate the clip logic from the span logic. Random commands vary origin, size, pitch, mode, clip window and acknowledge latency. Overlapping rows and stray writes show up in a full comparison of the memory image against a pixel-level model, together with the exact write address order and the read count.

// File: rtl/rfill_pkg.sv
package rfill_pkg;
  localparam int WORD_W = 32;
  localparam int WORD_LG = 5;

  typedef enum logic [1:0] {
    ALU_CLR0 = 2'd0,
    ALU_CLR  = 2'd1,
    ALU_SET  = 2'd2,
    ALU_TGL  = 2'd3
  } alu_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_RD,
    ST_WR
  } fill_state_e;
endpackage

// File: rtl/rfill_axis.sv
// One axis of the span: [lo, hi), optionally intersected with the clip window.
module rfill_axis #(
  parameter int CW = 11,
  localparam int EW = CW + 1
) (
  input  logic [CW-1:0] pos_i,
  input  logic [CW-1:0] len_i,
  input  logic [CW-1:0] cpos_i,
  input  logic [CW-1:0] clen_i,
  input  logic          clip_en_i,
  output logic [EW-1:0] lo_o,
  output logic [EW-1:0] hi_o
);
  logic [EW-1:0] cend;

  always_comb begin
    lo_o = {1'b0, pos_i};
    hi_o = {1'b0, pos_i} + {1'b0, len_i};
    cend = {1'b0, cpos_i} + {1'b0, clen_i};
    if (clip_en_i) begin
      if ({1'b0, cpos_i} > lo_o) lo_o = {1'b0, cpos_i};
      if (cend < hi_o) hi_o = cend;
    end
  end
endmodule

// File: rtl/rfill_mask.sv
// Bit mask of covered pixels in the current word; bit 31 = leftmost pixel.
module rfill_mask #(
  parameter int XW = 7
) (
  input  logic [XW-1:0] wx_i,
  input  logic [XW-1:0] wx_first_i,
  input  logic [XW-1:0] wx_last_i,
  input  logic [4:0]    lo_bit_i,
  input  logic [4:0]    hi_bit_i,
  output logic [31:0]   mask_o
);
  logic [4:0] lo_e, hi_e;

  always_comb begin
    lo_e   = (wx_i == wx_first_i) ? lo_bit_i : 5'd0;
    hi_e   = (wx_i == wx_last_i)  ? hi_bit_i : 5'd31;
    mask_o = (32'hFFFF_FFFF >> lo_e) & (32'hFFFF_FFFF << (5'd31 - hi_e));
  end
endmodule

// File: rtl/rfill_merge.sv
module rfill_merge
  import rfill_pkg::*;
(
  input  alu_mode_e   mode_i,
  input  logic [31:0] old_i,
  input  logic [31:0] mask_i,
  output logic [31:0] new_o
);
  always_comb begin
    unique case (mode_i)
      ALU_SET: new_o = old_i | mask_i;
      ALU_TGL: new_o = old_i ^ mask_i;
      default: new_o = old_i & ~mask_i;
    endcase
  end
endmodule

// File: rtl/rfill_engine.sv
module rfill_engine
  import rfill_pkg::*;
#(
  parameter int CW = 11,
  parameter int PW = 7,
  parameter int HW = 3,
  parameter int LW = 16,
  localparam int AW = HW + LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    alu_mode_i,
  input  logic [HW-1:0] dest_hi_i,
  input  logic [LW-1:0] dest_lo_i,
  input  logic [PW-1:0] pitch_i,
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] y_i,
  input  logic [CW-1:0] w_i,
  input  logic [CW-1:0] h_i,
  input  logic          clip_en_i,
  input  logic [CW-1:0] clip_x_i,
  input  logic [CW-1:0] clip_y_i,
  input  logic [CW-1:0] clip_w_i,
  input  logic [CW-1:0] clip_h_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ack_i
);
  localparam int EW = CW + 1;
  localparam int XW = EW - WORD_LG;

  // axis 0 = x, axis 1 = y
  logic [CW-1:0] a_pos [2];
  logic [CW-1:0] a_len [2];
  logic [CW-1:0] c_pos [2];
  logic [CW-1:0] c_len [2];
  logic [EW-1:0] a_lo  [2];
  logic [EW-1:0] a_hi  [2];

  assign a_pos[0] = x_i;
  assign a_pos[1] = y_i;
  assign a_len[0] = w_i;
  assign a_len[1] = h_i;
  assign c_pos[0] = clip_x_i;
  assign c_pos[1] = clip_y_i;
  assign c_len[0] = clip_w_i;
  assign c_len[1] = clip_h_i;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    rfill_axis #(.CW(CW)) u_axis (
      .pos_i    (a_pos[g]),
      .len_i    (a_len[g]),
      .cpos_i   (c_pos[g]),
      .clen_i   (c_len[g]),
      .clip_en_i(clip_en_i),
      .lo_o     (a_lo[g]),
      .hi_o     (a_hi[g])
    );
  end

  logic          empty;
  logic [AW-1:0] row_start;
  assign empty     = (a_hi[0] <= a_lo[0]) || (a_hi[1] <= a_lo[1]);
  assign row_start = {dest_hi_i, dest_lo_i} + AW'(a_lo[1]) * AW'(pitch_i);

  fill_state_e   st_q;
  alu_mode_e     mode_q;
  logic [PW-1:0] pitch_q;
  logic [EW-1:0] x0_q, xl_q, y_q, yl_q;
  logic [XW-1:0] wx_q;
  logic [AW-1:0] row_q;
  logic [31:0]   wdata_q;
  logic          done_q;
  logic [31:0]   mask;
  logic [31:0]   merged;
  logic          full_fast;

  rfill_mask #(.XW(XW)) u_mask (
    .wx_i      (wx_q),
    .wx_first_i(x0_q[EW-1:WORD_LG]),
    .wx_last_i (xl_q[EW-1:WORD_LG]),
    .lo_bit_i  (x0_q[WORD_LG-1:0]),
    .hi_bit_i  (xl_q[WORD_LG-1:0]),
    .mask_o    (mask)
  );

  rfill_merge u_merge (
    .mode_i(mode_q),
    .old_i (mem_rdata_i),
    .mask_i(mask),
    .new_o (merged)
  );

  // full word with a mode that ignores old contents: skip the read
  assign full_fast = (&mask) && (mode_q != ALU_TGL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mode_q  <= ALU_CLR0;
      pitch_q <= '0;
      x0_q    <= '0;
      xl_q    <= '0;
      y_q     <= '0;
      yl_q    <= '0;
      wx_q    <= '0;
      row_q   <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q  <= alu_mode_e'(alu_mode_i);
            pitch_q <= pitch_i;
            if (empty) begin
              done_q <= 1'b1;
            end else begin
              x0_q  <= a_lo[0];
              xl_q  <= a_hi[0] - EW'(1);
              y_q   <= a_lo[1];
              yl_q  <= a_hi[1] - EW'(1);
              wx_q  <= a_lo[0][EW-1:WORD_LG];
              row_q <= row_start;
              st_q  <= ST_PREP;
            end
          end
        end
        ST_PREP: begin
          wdata_q <= merged;
          st_q    <= full_fast ? ST_WR : ST_RD;
        end
        ST_RD: begin
          if (mem_ack_i) begin
            wdata_q <= merged;
            st_q    <= ST_WR;
          end
        end
        ST_WR: begin
          if (mem_ack_i) begin
            if (wx_q == xl_q[EW-1:WORD_LG]) begin
              if (y_q == yl_q) begin
                done_q <= 1'b1;
                st_q   <= ST_IDLE;
              end else begin
                y_q   <= y_q + EW'(1);
                row_q <= row_q + AW'(pitch_q);
                wx_q  <= x0_q[EW-1:WORD_LG];
                st_q  <= ST_PREP;
              end
            end else begin
              wx_q <= wx_q + XW'(1);
              st_q <= ST_PREP;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign mem_req_o   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = row_q + AW'(wx_q);
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/rfill_engine_chk.sv
module rfill_engine_chk #(
  parameter int AW = 19
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o
);
  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_rmw_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ack_i |=> mem_req_o && mem_we_o && $stable(mem_addr_o));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !mem_req_o);

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !busy_o && !done_o && !mem_req_o);
endmodule

bind rfill_engine rfill_engine_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_ack_i  (mem_ack_i),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o)
);

// File: tb/sim_rfill_engine.sv
`timescale 1ns/1ps
module sim_rfill_engine;
  localparam int CW = 11;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = '0;
  logic [2:0]    dhi = '0;
  logic [15:0]   dlo = '0;
  logic [6:0]    pitch = 7'd40;
  logic [CW-1:0] x = '0, y = '0, w = '0, h = '0;
  logic          cen = 1'b0;
  logic [CW-1:0] cx = '0, cy = '0, cw = '0, ch = '0;
  logic          busy, done, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          mem_ack = 1'b0;

  always #4 clk = ~clk;

  rfill_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .alu_mode_i(mode),
    .dest_hi_i(dhi), .dest_lo_i(dlo), .pitch_i(pitch),
    .x_i(x), .y_i(y), .w_i(w), .h_i(h),
    .clip_en_i(cen), .clip_x_i(cx), .clip_y_i(cy), .clip_w_i(cw), .clip_h_i(ch),
    .busy_o(busy), .done_o(done), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ack_i(mem_ack)
  );

  logic [31:0] mem   [int unsigned];
  logic [31:0] exp_m [int unsigned];
  int unsigned wr_q[$];
  int rd_cnt = 0;
  int n_chk = 0;
  int n_err = 0;

  function automatic logic [31:0] init_word(int unsigned a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic logic [31:0] exp_get(int unsigned a);
    return exp_m.exists(a) ? exp_m[a] : init_word(a);
  endfunction

  function automatic logic [31:0] mem_get(int unsigned a);
    return mem.exists(a) ? mem[a] : init_word(a);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv, string what);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
    end
  endtask

  // memory model with random acknowledge latency
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (rst_n && mem_req) begin
        int d;
        int unsigned a;
        d = int'($urandom % 3);
        repeat (d) @(negedge clk);
        a = int'(mem_addr);
        if (mem_we) begin
          mem[a] = mem_wdata;
          wr_q.push_back(a);
        end else begin
          mem_rdata = mem_get(a);
          rd_cnt++;
        end
        mem_ack = 1'b1;
      end
    end
  end

  task automatic run_cmd(int md, int dh, int dl, int pt, int px, int py, int pw, int ph,
                         bit ce, int qx, int qy, int qw, int qh, string tag, bit poke);
    int unsigned base, a;
    int ex0, ex1, ey0, ey1, ereads, cyc, dn, bad;
    int unsigned eq[$];
    base = dh * 65536 + dl;
    ex0 = px; ex1 = px + pw; ey0 = py; ey1 = py + ph;
    if (ce) begin
      if (qx > ex0) ex0 = qx;
      if (qx + qw < ex1) ex1 = qx + qw;
      if (qy > ey0) ey0 = qy;
      if (qy + qh < ey1) ey1 = qy + qh;
    end
    ereads = 0;
    if (ex1 > ex0 && ey1 > ey0) begin
      for (int yy = ey0; yy < ey1; yy++) begin
        for (int wx = ex0 / 32; wx <= (ex1 - 1) / 32; wx++) begin
          a = (base + yy * pt + wx) & ((1 << AW) - 1);
          eq.push_back(a);
          if (!(ex0 <= wx * 32 && ex1 >= wx * 32 + 32) || md == 3) ereads++;
        end
        for (int xx = ex0; xx < ex1; xx++) begin
          logic [31:0] v;
          int b;
          a = (base + yy * pt + xx / 32) & ((1 << AW) - 1);
          b = 31 - (xx % 32);
          v = exp_get(a);
          if (md == 2) v[b] = 1'b1;
          else if (md == 3) v[b] = ~v[b];
          else v[b] = 1'b0;
          exp_m[a] = v;
        end
      end
    end
    wr_q.delete();
    rd_cnt = 0;
    mode = md[1:0]; dhi = dh[2:0]; dlo = dl[15:0]; pitch = pt[6:0];
    x = px[CW-1:0]; y = py[CW-1:0]; w = pw[CW-1:0]; h = ph[CW-1:0];
    cen = ce; cx = qx[CW-1:0]; cy = qy[CW-1:0]; cw = qw[CW-1:0]; ch = qh[CW-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; dn = 0;
    forever begin
      cyc++;
      if (cyc == 1 && eq.size() != 0) chk("R10", busy, 1, "busy after start");
      if (done) dn++;
      if (done || cyc > 20000) break;
      if (poke && cyc == 3) begin start = 1'b1; mode = (md == 2) ? 2'd3 : 2'd2; end
      if (poke && cyc == 4) begin start = 1'b0; mode = md[1:0]; end
      @(negedge clk);
    end
    start = 1'b0;
    mode = md[1:0];
    chk("R10", (cyc > 20000) ? 0 : 1, 1, "watchdog per command");
    if (eq.size() == 0) chk((pw == 0 || ph == 0) ? "R8" : "R6", cyc, 1, "done cycle for empty");
    chk("R10", busy, 0, "busy at done");
    @(negedge clk);
    chk("R10", done, 0, "done width");
    chk("R2", wr_q.size(), eq.size(), {tag, " write count"});
    bad = 0;
    for (int i = 0; i < eq.size() && i < wr_q.size(); i++)
      if (wr_q[i] != eq[i]) bad++;
    chk("R2", bad, 0, {tag, " write order"});
    chk("R5", rd_cnt, ereads, {tag, " read count"});
    bad = 0;
    foreach (mem[k]) if (mem[k] !== exp_get(k)) bad++;
    foreach (exp_m[k]) if (exp_m[k] !== mem_get(k)) bad++;
    chk(tag, bad, 0, "memory image mismatches");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", {busy, done, mem_req}, 0, "reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {busy, done, mem_req}, 0, "idle after reset");

    run_cmd(2, 0, 100, 40, 5, 2, 10, 3, 0, 0, 0, 0, 0, "R3", 0);
    run_cmd(1, 0, 300, 40, 32, 1, 64, 2, 0, 0, 0, 0, 0, "R5", 0);
    run_cmd(3, 0, 300, 40, 32, 1, 64, 2, 0, 0, 0, 0, 0, "R4", 0);
    run_cmd(2, 0, 600, 20, 20, 0, 100, 4, 0, 0, 0, 0, 0, "R4", 0);
    run_cmd(0, 0, 600, 20, 30, 1, 50, 2, 0, 0, 0, 0, 0, "R4", 0);
    run_cmd(3, 0, 900, 8, 31, 0, 2, 3, 0, 0, 0, 0, 0, "R3", 0);
    run_cmd(2, 0, 1000, 40, 10, 5, 0, 4, 0, 0, 0, 0, 0, "R8", 0);
    run_cmd(2, 0, 1000, 40, 10, 5, 40, 0, 0, 0, 0, 0, 0, "R8", 0);
    run_cmd(2, 0, 1200, 30, 10, 2, 200, 10, 1, 40, 4, 70, 5, "R6", 0);
    run_cmd(3, 0, 1200, 30, 10, 2, 50, 5, 1, 300, 40, 20, 20, "R6", 0);
    run_cmd(2, 0, 1600, 30, 10, 2, 90, 4, 0, 300, 40, 5, 5, "R7", 0);
    run_cmd(2, 1, 0, 40, 0, 0, 70, 2, 0, 0, 0, 0, 0, "R2", 0);
    run_cmd(3, 0, 2000, 40, 3, 0, 300, 6, 0, 0, 0, 0, 0, "R10", 1);

    for (int i = 0; i < 40; i++) begin
      run_cmd(int'($urandom % 4), int'($urandom % 2), int'($urandom % 4096),
              1 + int'($urandom % 64), int'($urandom % 300), int'($urandom % 40),
              int'($urandom % 121), int'($urandom % 9), bit'($urandom % 2),
              int'($urandom % 300), int'($urandom % 40), int'($urandom % 200),
              int'($urandom % 30), "R3", 0);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule